// File: doc/BRIEF.md
# Byte/Word Selectable ROM Read Port

This block is a read-only memory port that presents one stored array of 16-bit words in either of two shapes, chosen by a mode input: as 16-bit words, or as 8-bit bytes at twice the address count. It takes a word-address bus, a mode select, an active-low chip enable and an output-enable input. The output-enable polarity is fixed at build time to active-high, active-low or ignored.

The port drives a 16-bit data bus together with a per-bit output-enable vector, so the pad ring outside the block can build the tri-state drivers. The top data bit shares a pin with the byte-address least significant bit. In word mode the port drives data bit 15 on that pin. In byte mode the pin is only an input, and the port reads its value on `byte_lsb_i` as the lowest byte-address bit.

Contents are held in a small internal array that is filled through a load port before reads begin. Reads are registered, so outputs reflect the address and enables sampled one clock earlier.

Top module: `rom_dual_width_port`

## Requirements
- R1: With `word_mode_i` high and the port enabled, `data_o` equals the stored word at `addr_i` and `data_oe_o` is 16'hFFFF, one clock after sampling.
- R2: With `word_mode_i` low and the port enabled, the byte address is {`addr_i`, `byte_lsb_i`}. Byte address 2n gives bits 7:0 of word n on `data_o[7:0]`, and 2n+1 gives bits 15:8 of word n.
- R3: In byte mode, `data_oe_o[14:8]` stays low.
- R4: In word mode with the port enabled, bit 15 of the word appears on `data_o[15]` with `data_oe_o[15]` high.
- R5: With `ce_n_i` high, `data_oe_o` is all zero one clock later, whatever `oe_i` is.
- R6: `OE_POL` = OE_ACT_HIGH enables on `oe_i`=1, OE_ACT_LOW enables on `oe_i`=0, and OE_IGNORED enables whenever `ce_n_i` is low. When not enabled, `data_oe_o` is all zero.
- R7: In byte mode, `data_oe_o[15]` stays low, so the shared pin acts only as an input.
- R8: While `rst_n` is low, `data_oe_o` and `data_o` are zero. Read results appear exactly one clock after the inputs are sampled.
- R9: Every bit of `data_o` whose `data_oe_o` bit is low reads zero.
- R10: A word written through the load port (`ld_en_i`, `ld_addr_i`, `ld_data_i`) on one clock edge is returned by reads sampled at later edges.
- R11: In word mode, `byte_lsb_i` has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_mode_i | input | 1 | 1 = 16-bit words, 0 = bytes |
| addr_i | input | ADDR_W | Word address (upper byte-address bits in byte mode) |
| byte_lsb_i | input | 1 | Input value of the shared bit-15 pin, used as byte-address LSB |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_i | input | 1 | Output enable, polarity set by OE_POL |
| ld_en_i | input | 1 | Load strobe for the contents array |
| ld_addr_i | input | ADDR_W | Load word address |
| ld_data_i | input | 16 | Load word data |
| data_o | output | 16 | Read data; bit 15 is the shared pin's output value |
| data_oe_o | output | 16 | Per-bit output enable for the pads |

## Verification
The bench builds three copies with ADDR_W = 5, one for each OE_POL setting, and drives all three from the same stimulus. Every polarity rule can therefore be checked on the same cycles. The array has 32 words, so random addressing covers every word and both byte halves many times. It also reaches mid-run reloads, chip-enable toggling and shared-pin values in both modes.

// File: rtl/rom_port_pkg.sv
package rom_port_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    OE_ACT_HIGH = 2'd0,
    OE_ACT_LOW  = 2'd1,
    OE_IGNORED  = 2'd2
  } oe_pol_e;

  localparam logic [WORD_W-1:0] LANES_WORD = {WORD_W{1'b1}};
  localparam logic [WORD_W-1:0] LANES_BYTE = {{(WORD_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
  localparam logic [WORD_W-1:0] LANES_NONE = '0;
endpackage

// File: rtl/rom_store.sv
module rom_store #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                              clk,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [rom_port_pkg::WORD_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]                 rd_addr,
  output logic [rom_port_pkg::WORD_W-1:0]   rd_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [rom_port_pkg::WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      cells[wr_addr] <= wr_data;
    end
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/oe_qualify.sv
module oe_qualify #(
  parameter rom_port_pkg::oe_pol_e OE_POL = rom_port_pkg::OE_ACT_LOW
) (
  input  logic ce_n,
  input  logic oe,
  output logic drive_en
);
  logic oe_ok;

  generate
    if (OE_POL == rom_port_pkg::OE_ACT_HIGH) begin : g_hi
      assign oe_ok = oe;
    end else if (OE_POL == rom_port_pkg::OE_ACT_LOW) begin : g_lo
      assign oe_ok = ~oe;
    end else begin : g_ign
      logic unused_oe;
      assign unused_oe = oe;
      assign oe_ok = 1'b1;
    end
  endgenerate

  assign drive_en = ~ce_n & oe_ok;
endmodule

// File: rtl/lane_steer.sv
module lane_steer (
  input  logic                              drive_en,
  input  logic                              word_mode,
  input  logic                              byte_sel,
  input  logic [rom_port_pkg::WORD_W-1:0]   word_in,
  output logic [rom_port_pkg::WORD_W-1:0]   data_nxt,
  output logic [rom_port_pkg::WORD_W-1:0]   lanes_nxt
);
  import rom_port_pkg::*;

  logic [BYTE_W-1:0] picked;

  always_comb begin
    picked = byte_sel ? word_in[WORD_W-1:BYTE_W] : word_in[BYTE_W-1:0];
    if (!drive_en) begin
      lanes_nxt = LANES_NONE;
      data_nxt  = '0;
    end else if (word_mode) begin
      lanes_nxt = LANES_WORD;
      data_nxt  = word_in;
    end else begin
      lanes_nxt = LANES_BYTE;
      data_nxt  = {{(WORD_W-BYTE_W){1'b0}}, picked};
    end
  end
endmodule

// File: rtl/rom_dual_width_port.sv
module rom_dual_width_port #(
  parameter int unsigned           ADDR_W = 8,
  parameter rom_port_pkg::oe_pol_e OE_POL = rom_port_pkg::OE_ACT_LOW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_lsb_i,
  input  logic              ce_n_i,
  input  logic              oe_i,
  input  logic              ld_en_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [15:0]       ld_data_i,
  output logic [15:0]       data_o,
  output logic [15:0]       data_oe_o
);
  import rom_port_pkg::*;

  logic              drive_en;
  logic [WORD_W-1:0] word_rd;
  logic [WORD_W-1:0] data_nxt;
  logic [WORD_W-1:0] lanes_nxt;
  logic [WORD_W-1:0] data_q;
  logic [WORD_W-1:0] lanes_q;
  logic              upd_en;

  rom_store #(.ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .wr_en   (ld_en_i),
    .wr_addr (ld_addr_i),
    .wr_data (ld_data_i),
    .rd_addr (addr_i),
    .rd_data (word_rd)
  );

  oe_qualify #(.OE_POL(OE_POL)) u_qual (
    .ce_n     (ce_n_i),
    .oe       (oe_i),
    .drive_en (drive_en)
  );

  lane_steer u_steer (
    .drive_en  (drive_en),
    .word_mode (word_mode_i),
    .byte_sel  (byte_lsb_i),
    .word_in   (word_rd),
    .data_nxt  (data_nxt),
    .lanes_nxt (lanes_nxt)
  );

  // output stage samples every cycle
  assign upd_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      lanes_q <= '0;
    end else if (upd_en) begin
      data_q  <= data_nxt;
      lanes_q <= lanes_nxt;
    end
  end

  assign data_o    = data_q;
  assign data_oe_o = lanes_q;
endmodule

// File: rtl/rom_port_checker.sv
module rom_port_checker #(
  parameter rom_port_pkg::oe_pol_e OE_POL = rom_port_pkg::OE_ACT_LOW
) (
  input logic        clk,
  input logic        rst_n,
  input logic        word_mode_i,
  input logic        ce_n_i,
  input logic        oe_i,
  input logic [15:0] data_o,
  input logic [15:0] data_oe_o
);
  logic primed;
  logic en_spec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  always_comb begin
    case (OE_POL)
      rom_port_pkg::OE_ACT_HIGH: en_spec = ~ce_n_i & oe_i;
      rom_port_pkg::OE_ACT_LOW:  en_spec = ~ce_n_i & ~oe_i;
      default:                   en_spec = ~ce_n_i;
    endcase
  end

  a_r5_ce_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(ce_n_i)) |-> (data_oe_o == 16'h0000));

  a_r3_upper_lanes_float: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$past(word_mode_i)) |-> (data_oe_o[14:8] == 7'h00));

  a_r7_shared_pin_input: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$past(word_mode_i)) |-> !data_oe_o[15]);

  a_r4_word_full_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(en_spec) && $past(word_mode_i)) |-> (data_oe_o == 16'hFFFF));

  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$past(en_spec)) |-> (data_oe_o == 16'h0000));

  a_r9_undriven_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (data_o & ~data_oe_o) == 16'h0000);
endmodule

bind rom_dual_width_port rom_port_checker #(.OE_POL(OE_POL)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .word_mode_i (word_mode_i),
  .ce_n_i      (ce_n_i),
  .oe_i        (oe_i),
  .data_o      (data_o),
  .data_oe_o   (data_oe_o)
);

// File: tb/tb_rom_dual_width_port.sv
`timescale 1ns/1ps
module tb_rom_dual_width_port;
  localparam int AW = 5;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic word_mode, lsb, ce_n, oe, ld_en;
  logic [AW-1:0] addr, ld_addr;
  logic [15:0] ld_data;
  logic [15:0] d_lo, e_lo, d_hi, e_hi, d_ig, e_ig;

  logic [15:0] ref_mem [DEPTH];
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rom_dual_width_port #(.ADDR_W(AW), .OE_POL(rom_port_pkg::OE_ACT_LOW)) dut (
    .clk(clk), .rst_n(rst_n), .word_mode_i(word_mode), .addr_i(addr),
    .byte_lsb_i(lsb), .ce_n_i(ce_n), .oe_i(oe), .ld_en_i(ld_en),
    .ld_addr_i(ld_addr), .ld_data_i(ld_data), .data_o(d_lo), .data_oe_o(e_lo));

  rom_dual_width_port #(.ADDR_W(AW), .OE_POL(rom_port_pkg::OE_ACT_HIGH)) dut_hi (
    .clk(clk), .rst_n(rst_n), .word_mode_i(word_mode), .addr_i(addr),
    .byte_lsb_i(lsb), .ce_n_i(ce_n), .oe_i(oe), .ld_en_i(ld_en),
    .ld_addr_i(ld_addr), .ld_data_i(ld_data), .data_o(d_hi), .data_oe_o(e_hi));

  rom_dual_width_port #(.ADDR_W(AW), .OE_POL(rom_port_pkg::OE_IGNORED)) dut_ig (
    .clk(clk), .rst_n(rst_n), .word_mode_i(word_mode), .addr_i(addr),
    .byte_lsb_i(lsb), .ce_n_i(ce_n), .oe_i(oe), .ld_en_i(ld_en),
    .ld_addr_i(ld_addr), .ld_data_i(ld_data), .data_o(d_ig), .data_oe_o(e_ig));

  // pol: 0 active-high, 1 active-low, 2 ignored
  function automatic logic en_of(int pol, logic c_n, logic o);
    if (c_n) return 1'b0;
    if (pol == 0) return o;
    if (pol == 1) return ~o;
    return 1'b1;
  endfunction

  function automatic logic [15:0] exp_lanes(logic en, logic wm);
    if (!en) return 16'h0000;
    return wm ? 16'hFFFF : 16'h00FF;
  endfunction

  function automatic logic [15:0] exp_data(logic en, logic wm, logic [AW-1:0] a, logic b);
    if (!en) return 16'h0000;
    if (wm) return ref_mem[a];
    return b ? {8'h00, ref_mem[a][15:8]} : {8'h00, ref_mem[a][7:0]};
  endfunction

  task automatic cmp(string tag, string who, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, who, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic e0, e1, e2;
    e1 = en_of(1, ce_n, oe);
    e0 = en_of(0, ce_n, oe);
    e2 = en_of(2, ce_n, oe);
    @(negedge clk);
    cmp(tag, "lo.oe", e_lo, exp_lanes(e1, word_mode));
    cmp(tag, "lo.d",  d_lo, exp_data(e1, word_mode, addr, lsb));
    cmp(tag, "hi.oe", e_hi, exp_lanes(e0, word_mode));
    cmp(tag, "hi.d",  d_hi, exp_data(e0, word_mode, addr, lsb));
    cmp(tag, "ig.oe", e_ig, exp_lanes(e2, word_mode));
    cmp(tag, "ig.d",  d_ig, exp_data(e2, word_mode, addr, lsb));
  endtask

  task automatic rd(string tag, logic wm, logic [AW-1:0] a, logic b, logic c_n, logic o);
    word_mode = wm; addr = a; lsb = b; ce_n = c_n; oe = o;
    check_all(tag);
  endtask

  task automatic load(logic [AW-1:0] a, logic [15:0] v);
    ld_en = 1'b1; ld_addr = a; ld_data = v;
    ref_mem[a] = v;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    string tg;
    void'($urandom(32'd7321));
    rst_n = 1'b0; word_mode = 1'b1; addr = '0; lsb = 1'b0;
    ce_n = 1'b0; oe = 1'b0; ld_en = 1'b0; ld_addr = '0; ld_data = '0;
    repeat (3) @(negedge clk);
    // R8: reset state with an enabled read requested
    cmp("R8", "lo.oe", e_lo, 16'h0000);
    cmp("R8", "lo.d",  d_lo, 16'h0000);
    cmp("R8", "ig.oe", e_ig, 16'h0000);
    rst_n = 1'b1;
    // R10: fill contents through the load port
    for (int i = 0; i < DEPTH; i++) load(i[AW-1:0], 16'($urandom));
    load(5'd9, 16'hA55A);
    // R1, R4: word reads, bit 15 on shared pin
    rd("R1", 1'b1, 5'd9, 1'b0, 1'b0, 1'b0);
    rd("R4", 1'b1, 5'd31, 1'b0, 1'b0, 1'b1);
    // R11: lsb toggles in word mode
    rd("R11", 1'b1, 5'd9, 1'b1, 1'b0, 1'b0);
    // R2, R3, R7: even and odd bytes of the same word
    rd("R2", 1'b0, 5'd9, 1'b0, 1'b0, 1'b0);
    rd("R2", 1'b0, 5'd9, 1'b1, 1'b0, 1'b1);
    rd("R3", 1'b0, 5'd0, 1'b1, 1'b0, 1'b0);
    rd("R7", 1'b0, 5'd31, 1'b1, 1'b0, 1'b1);
    // R5: chip disabled with either oe level
    rd("R5", 1'b1, 5'd9, 1'b0, 1'b1, 1'b0);
    rd("R5", 1'b1, 5'd9, 1'b0, 1'b1, 1'b1);
    // R6: each polarity sees both oe levels
    rd("R6", 1'b1, 5'd3, 1'b0, 1'b0, 1'b1);
    rd("R6", 1'b0, 5'd3, 1'b1, 1'b0, 1'b0);
    // R8: one-cycle latency on address change back to back
    rd("R8", 1'b1, 5'd1, 1'b0, 1'b0, 1'b0);
    rd("R8", 1'b1, 5'd2, 1'b0, 1'b0, 1'b0);
    // R10: reload then read the new value
    load(5'd2, 16'h1234);
    rd("R10", 1'b1, 5'd2, 1'b0, 1'b0, 1'b0);
    rd("R10", 1'b0, 5'd2, 1'b1, 1'b0, 1'b0);
    // random mix; R9 covered by every data compare
    for (int k = 0; k < 400; k++) begin
      logic wm, b, c, o;
      logic [AW-1:0] a;
      wm = 1'($urandom); b = 1'($urandom); o = 1'($urandom);
      c = (($urandom % 4) == 0);
      a = AW'($urandom);
      if (k % 50 == 25) load(AW'($urandom), 16'($urandom));
      tg = c ? "R5" : (wm ? "R1" : "R2");
      rd(tg, wm, a, b, c, o);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule